// File: doc/BRIEF.md
# Octal I/O Port Decoder and Bus Buffer

This block is the bus-side glue for a card that carries two serial controllers, each with a pair of registers. It takes the low eight address lines of a system bus, where every line is asserted low. It inverts them and matches the port number against two base addresses, which it treats as three octal digits. The top digit enables the middle digit, and the middle digit enables the bottom digit. The bottom stage looks only at even ports. Address bit 0 then chooses between the control register and the data register of the selected device. A swap input exchanges the two device selects, so either device can answer at either base.

The block also handles the data path between the active-low system data bus and the active-high local bus of the devices. Data flows inbound by default. It turns outbound only when a device is selected and an I/O read is in progress. The block also passes the device strobes through, and it inverts the system reset and the system clock for the devices.

Top module: `octal_port_decoder`

## Requirements
- R1: The decoder works on the inverted address. With swap_sel=0, dev_sel_n[0] is 0 exactly when ~addr_n[7:1] equals BASE_0[7:1] (default octal 372), and dev_sel_n[1] is 0 exactly when ~addr_n[7:1] equals BASE_1[7:1] (default octal 370).
- R2: The match is a cascade of three digit stages: bits 7:6, bits 5:3 and bits 2:1 of the true address. A mismatch in any one digit leaves both selects at 1.
- R3: Address bit 0 plays no part in selection. dev_reg_data equals ~addr_n[0]: 0 selects the control register and 1 selects the data register.
- R4: With swap_sel=1, dev_sel_n[0] follows the BASE_1 match and dev_sel_n[1] follows the BASE_0 match.
- R5: At most one of the two selects is low at any time.
- R6: sys_d_oe is 1 only when a select is low and io_rd_n is 0. While sys_d_oe is 1, sys_d_n_o equals ~loc_d_i. While sys_d_oe is 0, sys_d_n_o is all ones.
- R7: loc_rx_en is always the opposite of sys_d_oe. While loc_rx_en is 1, loc_d_o equals ~sys_d_n_i. While loc_rx_en is 0, loc_d_o is all zeros.
- R8: A select may go low with both strobes high, as in a memory cycle. In that case dev_rd_n and dev_wr_n stay high, because they copy io_rd_n and io_wr_n, and the outbound driver stays off.
- R9: dev_rst equals the inverse of rst_n_sys.
- R10: dev_clk equals the inverse of clk.
- R11: While io_wr_n is 0, sys_d_oe is 0, even if io_rd_n is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n_sys | input | 1 | System reset, active low |
| addr_n | input | 8 | Low address lines, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| swap_sel | input | 1 | Exchanges the two device selects |
| sys_d_n_i | input | DW | System data bus as received, active low |
| loc_d_i | input | DW | Local data from the devices |
| dev_clk | output | 1 | Inverted clock for the devices |
| dev_rst | output | 1 | Active-high device reset |
| dev_sel_n | output | 2 | Device chip selects, active low |
| dev_reg_data | output | 1 | 1 selects the data register, 0 the control register |
| dev_rd_n | output | 1 | Read strobe to the devices |
| dev_wr_n | output | 1 | Write strobe to the devices |
| sys_d_n_o | output | DW | Outbound system data, active low |
| sys_d_oe | output | 1 | Outbound driver enable |
| loc_d_o | output | DW | Inbound local data |
| loc_rx_en | output | 1 | Inbound receiver enable |

## Verification
The block holds no state, so a fault in any digit stage or in the swap steering appears on dev_sel_n in the same cycle the address is applied. An address that differs from a base in only one octal digit shows directly whether that stage gates the next one. A fault in the driver gating shows up as sys_d_oe rising during a write or a memory cycle, or as sys_d_n_o not returning to all ones. The bench sees either fault at the next sample point.

// File: rtl/octdec_pkg.sv
package octdec_pkg;

    localparam int ADDR_W  = 8;
    localparam int NUM_DEV = 2;
    localparam int HI_W    = 2;
    localparam int MID_W   = 3;
    localparam int LO_W    = 2;

    // True (active-high) port number split into its octal digit fields.
    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [MID_W-1:0] mid;
        logic [LO_W-1:0]  lo_even;
        logic             reg_sel;
    } port_addr_t;

    function automatic port_addr_t split_port(input logic [ADDR_W-1:0] a);
        port_addr_t p;
        p.hi      = a[7:6];
        p.mid     = a[5:3];
        p.lo_even = a[2:1];
        p.reg_sel = a[0];
        return p;
    endfunction

endpackage

// File: rtl/oct_digit_stage.sv
module oct_digit_stage #(
    parameter int W = 3
) (
    input  logic         en,
    input  logic [W-1:0] digit,
    input  logic [W-1:0] want,
    output logic         hit
);
    always_comb hit = en && (digit == want);
endmodule

// File: rtl/port_match.sv
module port_match
    import octdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 8'o372
) (
    input  port_addr_t pa,
    output logic       hit
);
    localparam port_addr_t WANT = split_port(BASE);

    logic hi_hit;
    logic mid_hit;

    oct_digit_stage #(.W(HI_W)) u_hi (
        .en(1'b1), .digit(pa.hi), .want(WANT.hi), .hit(hi_hit)
    );
    oct_digit_stage #(.W(MID_W)) u_mid (
        .en(hi_hit), .digit(pa.mid), .want(WANT.mid), .hit(mid_hit)
    );
    oct_digit_stage #(.W(LO_W)) u_lo (
        .en(mid_hit), .digit(pa.lo_even), .want(WANT.lo_even), .hit(hit)
    );
endmodule

// File: rtl/sel_steer.sv
module sel_steer
    import octdec_pkg::*;
(
    input  logic [NUM_DEV-1:0] match,
    input  logic               swap,
    output logic [NUM_DEV-1:0] sel_n
);
    always_comb begin
        for (int i = 0; i < NUM_DEV; i++) begin
            sel_n[i] = swap ? ~match[NUM_DEV-1-i] : ~match[i];
        end
    end
endmodule

// File: rtl/bus_buffer.sv
module bus_buffer #(
    parameter int DW = 8
) (
    input  logic          any_sel,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] sys_in_n,
    input  logic [DW-1:0] loc_in,
    output logic [DW-1:0] sys_out_n,
    output logic          drive,
    output logic [DW-1:0] loc_out,
    output logic          rx
);
    always_comb begin
        drive     = any_sel && !rd_n && wr_n;
        rx        = !drive;
        sys_out_n = drive ? ~loc_in : '1;
        loc_out   = rx ? ~sys_in_n : '0;
    end
endmodule

// File: rtl/octal_port_decoder.sv
module octal_port_decoder
    import octdec_pkg::*;
#(
    parameter int                DW     = 8,
    parameter logic [ADDR_W-1:0] BASE_0 = 8'o372,
    parameter logic [ADDR_W-1:0] BASE_1 = 8'o370
) (
    input  logic              clk,
    input  logic              rst_n_sys,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    input  logic              swap_sel,
    input  logic [DW-1:0]     sys_d_n_i,
    input  logic [DW-1:0]     loc_d_i,
    output logic              dev_clk,
    output logic              dev_rst,
    output logic [1:0]        dev_sel_n,
    output logic              dev_reg_data,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic [DW-1:0]     sys_d_n_o,
    output logic              sys_d_oe,
    output logic [DW-1:0]     loc_d_o,
    output logic              loc_rx_en
);
    localparam logic [NUM_DEV*ADDR_W-1:0] BASES = {BASE_1, BASE_0};

    port_addr_t         pa;
    logic [NUM_DEV-1:0] match;

    always_comb pa = split_port(~addr_n);

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        port_match #(.BASE(BASES[d*ADDR_W +: ADDR_W])) u_match (
            .pa(pa), .hit(match[d])
        );
    end

    sel_steer u_steer (
        .match(match), .swap(swap_sel), .sel_n(dev_sel_n)
    );

    bus_buffer #(.DW(DW)) u_buf (
        .any_sel  (dev_sel_n != '1),
        .rd_n     (io_rd_n),
        .wr_n     (io_wr_n),
        .sys_in_n (sys_d_n_i),
        .loc_in   (loc_d_i),
        .sys_out_n(sys_d_n_o),
        .drive    (sys_d_oe),
        .loc_out  (loc_d_o),
        .rx       (loc_rx_en)
    );

    always_comb begin
        dev_clk      = ~clk;
        dev_rst      = ~rst_n_sys;
        dev_reg_data = pa.reg_sel;
        dev_rd_n     = io_rd_n;
        dev_wr_n     = io_wr_n;
    end
endmodule

// File: rtl/octal_port_decoder_chk.sv
module octal_port_decoder_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          dev_rst,
    input logic          io_rd_n,
    input logic          io_wr_n,
    input logic [1:0]    dev_sel_n,
    input logic          sys_d_oe,
    input logic          loc_rx_en,
    input logic [DW-1:0] sys_d_n_o
);
    assert_one_sel_R5: assert property (@(posedge clk) disable iff (dev_rst)
        $countones(~dev_sel_n) <= 1);

    assert_drv_needs_rd_R6: assert property (@(posedge clk) disable iff (dev_rst)
        sys_d_oe |-> (!io_rd_n && dev_sel_n != 2'b11));

    assert_bus_released_R6: assert property (@(posedge clk) disable iff (dev_rst)
        !sys_d_oe |-> (sys_d_n_o == '1));

    assert_rx_opposes_drv_R7: assert property (@(posedge clk) disable iff (dev_rst)
        loc_rx_en != sys_d_oe);

    assert_no_drv_on_write_R11: assert property (@(posedge clk) disable iff (dev_rst)
        !io_wr_n |-> !sys_d_oe);
endmodule

bind octal_port_decoder octal_port_decoder_chk #(.DW(DW)) u_chk (
    .clk(clk), .dev_rst(dev_rst), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .dev_sel_n(dev_sel_n), .sys_d_oe(sys_d_oe), .loc_rx_en(loc_rx_en),
    .sys_d_n_o(sys_d_n_o)
);

// File: tb/octal_port_decoder_test.sv
`timescale 1ns/1ps
module octal_port_decoder_test;

    typedef struct packed {
        logic [1:0] sel_n;
        logic       reg_d;
        logic       oe;
        logic       rx;
        logic [7:0] sys_o;
        logic [7:0] loc_o;
        logic       rd_n;
        logic       wr_n;
        logic       rst;
    } obs_t;

    logic       clk = 1'b0;
    logic       rst_n_sys = 1'b0;
    logic [7:0] addr_n = 8'hFF;
    logic       io_rd_n = 1'b1;
    logic       io_wr_n = 1'b1;
    logic       swap_sel = 1'b0;
    logic [7:0] sys_d_n_i = 8'hFF;
    logic [7:0] loc_d_i = 8'h00;
    logic       dev_clk, dev_rst, dev_reg_data, dev_rd_n, dev_wr_n;
    logic [1:0] dev_sel_n;
    logic [7:0] sys_d_n_o, loc_d_o;
    logic       sys_d_oe, loc_rx_en;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    obs_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    octal_port_decoder uut (
        .clk(clk), .rst_n_sys(rst_n_sys), .addr_n(addr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .swap_sel(swap_sel),
        .sys_d_n_i(sys_d_n_i), .loc_d_i(loc_d_i),
        .dev_clk(dev_clk), .dev_rst(dev_rst), .dev_sel_n(dev_sel_n),
        .dev_reg_data(dev_reg_data), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
        .sys_d_n_o(sys_d_n_o), .sys_d_oe(sys_d_oe),
        .loc_d_o(loc_d_o), .loc_rx_en(loc_rx_en)
    );

    // Expected outputs derived from the requirements (bases octal 372 and 370).
    function automatic obs_t model(input logic [7:0] an, input logic rdn,
                                   input logic wrn, input logic sw,
                                   input logic [7:0] sd, input logic [7:0] ld,
                                   input logic rn);
        obs_t e;
        logic [7:0] a;
        logic m0, m1, s0, s1, oe;
        a  = ~an;
        m0 = (a[7:1] == 7'b1111101);
        m1 = (a[7:1] == 7'b1111100);
        s0 = sw ? m1 : m0;
        s1 = sw ? m0 : m1;
        oe = (s0 || s1) && !rdn && wrn;
        e.sel_n = {~s1, ~s0};
        e.reg_d = a[0];
        e.oe    = oe;
        e.rx    = !oe;
        e.sys_o = oe ? ~ld : 8'hFF;
        e.loc_o = oe ? 8'h00 : ~sd;
        e.rd_n  = rdn;
        e.wr_n  = wrn;
        e.rst   = !rn;
        return e;
    endfunction

    task automatic apply(input logic [7:0] port, input logic rdn, input logic wrn,
                         input logic sw, input logic [7:0] sd, input logic [7:0] ld,
                         input logic rn, input string tag);
        @(posedge clk);
        #1;
        addr_n    = ~port;
        io_rd_n   = rdn;
        io_wr_n   = wrn;
        swap_sel  = sw;
        sys_d_n_i = sd;
        loc_d_i   = ld;
        rst_n_sys = rn;
        exp_q.push_back(model(~port, rdn, wrn, sw, sd, ld, rn));
        tag_q.push_back(tag);
    endtask

    // Monitor: compares at the falling edge, away from input changes.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            obs_t  e;
            obs_t  got;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = '{sel_n: dev_sel_n, reg_d: dev_reg_data, oe: sys_d_oe,
                    rx: loc_rx_en, sys_o: sys_d_n_o, loc_o: loc_d_o,
                    rd_n: dev_rd_n, wr_n: dev_wr_n, rst: dev_rst};
            compared++;
            if (got !== e) begin
                mismatched++;
                $display("FAIL %s actual=%h expected=%h", t, got, e);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        apply(8'o000, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, "R9 reset held");
        apply(8'o000, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b1, "R9 reset released");
        apply(8'o372, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h5A, 1'b1, "R1 R6 dev0 control read");
        apply(8'o373, 1'b0, 1'b1, 1'b0, 8'h3C, 8'hC3, 1'b1, "R3 dev0 data read");
        apply(8'o370, 1'b1, 1'b0, 1'b0, 8'h96, 8'h11, 1'b1, "R1 R7 dev1 control write");
        apply(8'o371, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h22, 1'b1, "R3 R7 dev1 data write");
        apply(8'o374, 1'b0, 1'b1, 1'b0, 8'h55, 8'h33, 1'b1, "R2 low digit miss");
        apply(8'o362, 1'b0, 1'b1, 1'b0, 8'h55, 8'h33, 1'b1, "R2 middle digit miss");
        apply(8'o272, 1'b0, 1'b1, 1'b0, 8'h55, 8'h33, 1'b1, "R2 high digit miss");
        apply(8'o372, 1'b0, 1'b1, 1'b1, 8'hA0, 8'h44, 1'b1, "R4 swap base0 to dev1");
        apply(8'o371, 1'b0, 1'b1, 1'b1, 8'hA0, 8'h77, 1'b1, "R4 R3 swap base1 to dev0");
        apply(8'o372, 1'b1, 1'b1, 1'b0, 8'h12, 8'h34, 1'b1, "R8 memory cycle no strobe");
        apply(8'o373, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34, 1'b1, "R11 read and write together");
        apply(8'o376, 1'b0, 1'b1, 1'b0, 8'hE7, 8'h34, 1'b1, "R6 read unmatched port");
        apply(8'o370, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, "R5 R6 dev1 read all ones");
        // R10: device clock is the inverse of the system clock.
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            compared++;
            if (dev_clk !== 1'b0) begin
                mismatched++;
                $display("FAIL R10 actual=%b expected=0", dev_clk);
            end
            @(negedge clk);
            #1;
            compared++;
            if (dev_clk !== 1'b1) begin
                mismatched++;
                $display("FAIL R10 actual=%b expected=1", dev_clk);
            end
        end
        wait (exp_q.size() == 0);
        @(posedge clk);
        finish_run();
    end

endmodule